// File: doc/BRIEF.md
# Address-Latched Bit-Wide Static RAM

This block models a static memory of 1024 one-bit words behind an asynchronous-style control pair: an active-low chip enable and an active-low write enable. A system clock samples both controls. The block compares each sample with the previous one to find their edges. When chip enable falls, the address is captured in an internal register, and that register selects the word for the whole cycle. Later changes on the address pins have no effect until the next fall.

A write runs while both controls are low. It ends at whichever control rises first, and the data input present at that terminating sample is stored. Write enable may stay low across many chip-enable pulses, so a string of locations can be written one after another. The data output is a value plus a drive flag. The flag is dropped whenever chip enable is high or write enable is low, so input and output can share one bus. With chip enable low and write enable high, the addressed bit is driven one clock after the fall is seen. A later write pulse in the same cycle gives a read-then-write. The memory is not cleared by reset.

Top module: `latched_bit_ram`

## Requirements
- R1: The block holds 1024 independent one-bit locations selected by a 10-bit address, and each location can be written and read back without disturbing any other.
- R2: The address is captured at the clock edge that first samples chipEnN low after a high sample. Address changes after that edge do not change which location is read or written in that cycle.
- R3: Storage changes only after an interval in which both chipEnN and wrEnN were sampled low. Holding wrEnN low with chipEnN high, or chipEnN low with wrEnN high, leaves every location unchanged.
- R4: A write is committed at the first edge that samples chipEnN or wrEnN high after both were low, and dataIn sampled at that same edge is the value stored. Earlier dataIn values in the write period are discarded.
- R5: With wrEnN held low, each chipEnN low pulse writes dataIn to the address latched at that pulse's fall, and the write commits when chipEnN rises.
- R6: dataOutEn is 0 after any edge that samples chipEnN high.
- R7: dataOutEn is 0 after any edge that samples wrEnN low.
- R8: On a read (chipEnN low, wrEnN high), dataOutEn stays 0 after the fall-detecting edge. After the next edge it is 1, and dataOut shows the bit at the latched address.
- R9: In one chipEnN-low period, a read may be followed by any number of write pulses. After each wrEnN rise, dataOut is driven with the bit just committed.
- R10: Reset returns both edge detectors to the idle state (both controls seen high) and leaves dataOutEn 0. Memory contents survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; controls are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the control state and output flag |
| chipEnN | input | 1 | Active-low chip enable; its fall starts a cycle and latches the address |
| wrEnN | input | 1 | Active-low write enable |
| addrIn | input | 10 | Word address, captured at the chipEnN fall |
| dataIn | input | 1 | Write data, stored at the terminating edge |
| dataOut | output | 1 | Read data value, meaningful only while dataOutEn is 1 |
| dataOutEn | output | 1 | 1 when dataOut must be driven onto the bus |

## Verification
Every address is first written with an arithmetic bit pattern using chip-enable-terminated writes. During each write, dataIn changes mid-period and the address pins are scrambled after the fall. This separates the latched address from the live pins, and data from the terminating edge from earlier data. A full read sweep follows. The complement pattern is then written in back-to-back mode with write enable held low and read back, which separates the two write-termination styles and shows that every bit can be changed. Read-then-write cycles with repeated write-enable pulses, a long write-enable-low spell with chip enable high, and a reset followed by reads cover output release, write-enable termination, writes that have no effect, and retention across reset.

// File: rtl/latched_bit_ram_pkg.sv
package latched_bit_ram_pkg;
  // Strobes from the control to the datapath, valid for one clock edge.
  typedef struct packed {
    logic latchAddr;  // cycle start: capture the address pins
    logic commit;     // write terminated: store dataIn
    logic drive;      // output driven after this edge
  } ramStrobe_t;
endpackage

// File: rtl/latched_bit_ram_ctrl.sv
module latched_bit_ram_ctrl
  import latched_bit_ram_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chipEnN,
  input  logic       wrEnN,
  output ramStrobe_t strobe
);
  // Previous samples of the two controls; the idle level is high.
  logic eSmp;
  logic wSmp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eSmp <= 1'b1;
      wSmp <= 1'b1;
    end else begin
      eSmp <= chipEnN;
      wSmp <= wrEnN;
    end
  end

  logic eFall;
  logic writeOpen;
  logic writeEnd;

  assign eFall     = eSmp & ~chipEnN;
  assign writeOpen = ~eSmp & ~wSmp;
  assign writeEnd  = chipEnN | wrEnN;

  always_comb begin
    strobe.latchAddr = eFall;
    strobe.commit    = writeOpen & writeEnd;
    strobe.drive     = ~eSmp & ~chipEnN & wrEnN;
  end
endmodule

// File: rtl/latched_bit_ram_dp.sv
module latched_bit_ram_dp
  import latched_bit_ram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ramStrobe_t        strobe,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              dataIn,
  output logic              dataOut,
  output logic              dataOutEn
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0]  memBits;
  logic [ADDR_W-1:0] addrLat;
  logic              rdBit;

  // Storage is never reset.
  always_ff @(posedge clk) begin
    if (strobe.commit) memBits[addrLat] <= dataIn;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addrLat <= '0;
    end else if (strobe.latchAddr) begin
      addrLat <= addrIn;
    end
  end

  // A bit committed at this edge bypasses the array for the output.
  assign rdBit = strobe.commit ? dataIn : memBits[addrLat];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dataOutEn <= 1'b0;
      dataOut   <= 1'b0;
    end else begin
      dataOutEn <= strobe.drive;
      dataOut   <= strobe.drive & rdBit;
    end
  end
endmodule

// File: rtl/latched_bit_ram.sv
module latched_bit_ram
  import latched_bit_ram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chipEnN,
  input  logic              wrEnN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              dataIn,
  output logic              dataOut,
  output logic              dataOutEn
);
  ramStrobe_t strobe;

  latched_bit_ram_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .chipEnN (chipEnN),
    .wrEnN   (wrEnN),
    .strobe  (strobe)
  );

  latched_bit_ram_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .addrIn    (addrIn),
    .dataIn    (dataIn),
    .dataOut   (dataOut),
    .dataOutEn (dataOutEn)
  );
endmodule

// File: rtl/latched_bit_ram_chk.sv
module latched_bit_ram_chk (
  input logic clk,
  input logic rst_n,
  input logic chipEnN,
  input logic wrEnN,
  input logic dataOut,
  input logic dataOutEn
);
  // The checker's own record of the previous chip-enable sample.
  logic ePrv;
  always_ff @(posedge clk) begin
    if (!rst_n) ePrv <= 1'b1;
    else        ePrv <= chipEnN;
  end

  a_r6_off_when_e_high: assert property (@(posedge clk) disable iff (!rst_n)
    chipEnN |=> !dataOutEn);

  a_r7_off_when_w_low: assert property (@(posedge clk) disable iff (!rst_n)
    !wrEnN |=> !dataOutEn);

  a_r8_off_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (ePrv && !chipEnN) |=> !dataOutEn);

  a_r8_on_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!ePrv && !chipEnN && wrEnN) |=> dataOutEn);

  // R2: a continuous read of the latched location gives a steady value.
  a_r2_read_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (dataOutEn && $past(dataOutEn)) |-> $stable(dataOut));

  // R10: the output is released while reset is applied.
  always_ff @(posedge clk) begin
    if (!rst_n) ;
    else if ($past(!rst_n)) a_r10_idle_after_reset: assert (!dataOutEn);
  end
endmodule

bind latched_bit_ram latched_bit_ram_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .chipEnN   (chipEnN),
  .wrEnN     (wrEnN),
  .dataOut   (dataOut),
  .dataOutEn (dataOutEn)
);

// File: tb/latched_bit_ram_bench.sv
`timescale 1ns/1ps
module latched_bit_ram_bench;
  localparam int AW = 10;
  localparam int N  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chipEnN = 1'b1;
  logic wrEnN = 1'b1;
  logic [AW-1:0] addrIn = '0;
  logic dataIn = 1'b0;
  logic dataOut;
  logic dataOutEn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  latched_bit_ram #(.ADDR_W(AW)) u_latched_bit_ram (
    .clk(clk), .rst_n(rst_n), .chipEnN(chipEnN), .wrEnN(wrEnN),
    .addrIn(addrIn), .dataIn(dataIn), .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

  function automatic logic patBit(input int a);
    return logic'(((a * 5) + (a >> 3) + (a >> 7)) & 1);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Write terminated by chip enable; D changes mid-period, address pins scrambled.
  task automatic writeByE(input int a, input logic b);
    chipEnN = 1'b0; wrEnN = 1'b1; addrIn = AW'(a); dataIn = ~b;
    step();                                    // address latched
    addrIn = AW'(a ^ 10'h3A5); wrEnN = 1'b0;
    step();                                    // write open
    dataIn = b; chipEnN = 1'b1;
    step();                                    // committed here
    wrEnN = 1'b1; dataIn = ~b;
    step();
  endtask

  // Read with checks on the release and drive timing.
  task automatic readAt(input int a, input logic exp, input bit timing);
    chipEnN = 1'b0; wrEnN = 1'b1; addrIn = AW'(a);
    step();
    if (timing) check("R8 off at fall", dataOutEn, 1'b0);
    addrIn = AW'(~a);
    step();
    check("R8 drive", dataOutEn, 1'b1);
    check("R1/R2 read value", dataOut, exp);
    chipEnN = 1'b1;
    step();
    if (timing) check("R6 release on E high", dataOutEn, 1'b0);
  endtask

  initial begin
    repeat (3) step();
    check("R10 reset output off", dataOutEn, 1'b0);
    rst_n = 1'b1;
    step();
    check("R10 idle after reset", dataOutEn, 1'b0);

    // R1 R2 R4: pattern written with E-terminated writes.
    for (int a = 0; a < N; a++) writeByE(a, patBit(a));
    for (int a = 0; a < N; a++) readAt(a, patBit(a), a < 8);

    // R5: complement written with W held low across E pulses.
    wrEnN = 1'b0;
    for (int a = 0; a < N; a++) begin
      chipEnN = 1'b0; addrIn = AW'(a); dataIn = ~patBit(a);
      step();
      if (a < 4) check("R7 off while W low", dataOutEn, 1'b0);
      chipEnN = 1'b1; addrIn = AW'(a + 1);
      step();
    end
    wrEnN = 1'b1;
    step();
    for (int a = 0; a < N; a++) readAt(a, ~patBit(a), 1'b0);

    // R3: W low with E high for a while, D toggling: nothing written.
    wrEnN = 1'b0;
    for (int k = 0; k < 6; k++) begin
      addrIn = AW'(k); dataIn = patBit(k);
      step();
    end
    wrEnN = 1'b1;
    step();
    for (int a = 0; a < 6; a++) readAt(a, ~patBit(a), 1'b0);

    // R9: read, then two write pulses in one E-low period at address 77.
    chipEnN = 1'b0; wrEnN = 1'b1; addrIn = AW'(77);
    step();
    addrIn = AW'(5);
    step();
    check("R9 read before write", dataOut, ~patBit(77));
    wrEnN = 1'b0; dataIn = ~patBit(77);
    step();
    check("R7 release on W low", dataOutEn, 1'b0);
    dataIn = patBit(77);
    step();
    wrEnN = 1'b1;
    step();                                    // W rise commits patBit(77)
    check("R9 drive after W rise", dataOutEn, 1'b1);
    check("R4 W-terminated value", dataOut, patBit(77));
    wrEnN = 1'b0; dataIn = ~patBit(77);
    step();
    wrEnN = 1'b1;
    step();
    check("R9 second rewrite", dataOut, ~patBit(77));
    chipEnN = 1'b1;
    step();
    readAt(77, ~patBit(77), 1'b1);
    readAt(5, ~patBit(5), 1'b0);

    // R10: reset keeps memory.
    rst_n = 1'b0;
    repeat (2) step();
    check("R10 output off in reset", dataOutEn, 1'b0);
    rst_n = 1'b1;
    step();
    for (int a = 100; a < 116; a++) readAt(a, ~patBit(a), 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule